// File: doc/BRIEF.md
# I2C EEPROM Single-Byte Access Master

This block is an I2C bus master for small serial EEPROMs with byte-wide cells and one-byte cell addressing. A host presents a 7-bit device address, an 8-bit cell address, a direction select, a data byte for writes and a start strobe. The block then frames the whole bus transaction without further host involvement.

A write sends the device address, the cell address and the data byte. A read sends the device address and the cell address, then a repeated START and the device address again with the read direction. It receives one byte, answers it with NACK, and ends with STOP.

The block drives SCL and SDA through open-drain enables and reads SDA back from the wired line. The SCL half period is set in system-clock cycles by a host input. At a 100 MHz clock, a value of 500 gives 100 kHz. When a transaction ends, a one-cycle done pulse reports it, together with an error flag and the received byte.

Top module: `i2c_ee_byte_master`

## Requirements
- R1: The first byte after each START or repeated START is the 7-bit device address in bits 7..1, with the direction in bit 0 (0 = write, 1 = read). Every byte goes out most significant bit first, and after each byte the SDA line is released for one ACK clock.
- R2: With rd_nwr = 0, the bus sequence is: START, the device address with write direction, the cell address, the data byte, STOP.
- R3: With rd_nwr = 1, the bus sequence is: START, the device address with write direction, the cell address, a repeated START with no STOP before it, and the device address with read direction. The master then receives eight bits with SDA released, releases SDA for the ninth clock (NACK) and sends STOP.
- R4: Every SCL low half, every SCL high half and every START or STOP hold step lasts exactly half_cnt clock cycles. A half_cnt of 0 behaves as 1.
- R5: scl_oe = 1 or sda_oe = 1 pulls the matching line low, and 0 releases it. While busy is low, both enables are 0.
- R6: While SCL stays released, SDA changes only in two cases: it falls at a START or repeated START, and it rises at a STOP.
- R7: If SDA reads high in the ACK clock after any transmitted byte, the block sends no further bytes. It goes straight to STOP, then pulses done with err = 1.
- R8: A start strobe is ignored while busy is high. The input values present at that time do not change the transaction in progress.
- R9: done is high for exactly one cycle per transaction. rd_data takes the received byte, assembled MSB first, only when a read completes without NACK. Otherwise rd_data keeps its value.
- R10: After reset, both lines are released, busy, done and err are 0, and rd_data is 0.
- R11: A start strobe in the cycle where done is high is accepted, and the next transaction begins at the following clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| half_cnt | input | CW | SCL half period in clock cycles |
| start | input | 1 | Start strobe, sampled while idle |
| rd_nwr | input | 1 | 1 = random read, 0 = byte write |
| dev_addr | input | 7 | 7-bit device address |
| mem_addr | input | 8 | Cell address inside the EEPROM |
| wr_data | input | 8 | Byte to write |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle end-of-transaction pulse |
| err | output | 1 | Last transaction ended on a NACK |
| rd_data | output | 8 | Last byte read |
| scl_oe | output | 1 | Pull SCL low when 1 |
| sda_oe | output | 1 | Pull SDA low when 1 |
| sda_in | input | 1 | Sampled SDA line level |

## Verification
The end-of-transaction done pulse and the acceptance of a new start strobe can fall in the same cycle. The bench provokes this by raising start in exactly the cycle done is expected. The reference waveform for the second transaction must then begin at the very next edge, with no idle cycle. A strobe raised in the middle of a transfer, with different address and direction values, must leave the expected waveform and the final result unchanged. A reference model drives the EEPROM's side of SDA and compares both enables, busy and done cycle by cycle.

// File: rtl/i2c_ee_byte_master.sv
module i2c_ee_byte_master #(
  parameter int CW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] half_cnt,
  input  logic          start,
  input  logic          rd_nwr,
  input  logic [6:0]    dev_addr,
  input  logic [7:0]    mem_addr,
  input  logic [7:0]    wr_data,
  output logic          busy,
  output logic          done,
  output logic          err,
  output logic [7:0]    rd_data,
  output logic          scl_oe,
  output logic          sda_oe,
  input  logic          sda_in
);

  typedef enum logic [3:0] {
    S_IDLE, S_START, S_LOW, S_HIGH, S_RS_LOW, S_RS_HIGH, S_P_LOW, S_P_HIGH, S_P_END
  } st_t;

  st_t           st;
  logic [CW-1:0] cnt;
  logic [3:0]    bitn;
  logic [1:0]    idx;
  logic [7:0]    sh;
  logic          rd_q;
  logic [6:0]    dev_q;
  logic [7:0]    mem_q, wd_q;
  logic          past_ok;

  wire [CW-1:0] reload = (half_cnt == '0) ? '0 : half_cnt - CW'(1);
  wire tick      = (cnt == '0);
  wire is_rx     = rd_q && (idx == 2'd3);
  wire last_byte = rd_q ? (idx == 2'd3) : (idx == 2'd2);
  wire in_byte   = (st == S_LOW) || (st == S_HIGH);
  wire drive_bit = in_byte && (bitn != 4'd8) && !is_rx && !sh[7];

  assign busy   = (st != S_IDLE);
  assign scl_oe = (st == S_LOW) || (st == S_RS_LOW) || (st == S_P_LOW);
  assign sda_oe = drive_bit || (st == S_START) || (st == S_P_LOW) || (st == S_P_HIGH);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      cnt     <= '0;
      bitn    <= '0;
      idx     <= '0;
      sh      <= '0;
      rd_q    <= 1'b0;
      dev_q   <= '0;
      mem_q   <= '0;
      wd_q    <= '0;
      done    <= 1'b0;
      err     <= 1'b0;
      rd_data <= '0;
    end else begin
      done <= 1'b0;
      if (st == S_IDLE) begin
        if (start) begin
          rd_q  <= rd_nwr;
          dev_q <= dev_addr;
          mem_q <= mem_addr;
          wd_q  <= wr_data;
          err   <= 1'b0;
          idx   <= '0;
          bitn  <= '0;
          sh    <= {dev_addr, 1'b0};
          cnt   <= reload;
          st    <= S_START;
        end
      end else if (!tick) begin
        cnt <= cnt - CW'(1);
      end else begin
        cnt <= reload;
        case (st)
          S_START:   st <= S_LOW;
          S_LOW:     st <= S_HIGH;
          S_HIGH: begin
            if (bitn != 4'd8) begin
              sh   <= {sh[6:0], sda_in};
              bitn <= bitn + 4'd1;
              st   <= S_LOW;
            end else begin
              bitn <= '0;
              if (!is_rx && sda_in) begin
                err <= 1'b1;
                st  <= S_P_LOW;
              end else if (last_byte) begin
                if (is_rx) rd_data <= sh;
                st <= S_P_LOW;
              end else if (rd_q && idx == 2'd1) begin
                idx <= 2'd2;
                sh  <= {dev_q, 1'b1};
                st  <= S_RS_LOW;
              end else begin
                idx <= idx + 2'd1;
                sh  <= (idx == 2'd0) ? mem_q : (idx == 2'd1) ? wd_q : 8'hFF;
                st  <= S_LOW;
              end
            end
          end
          S_RS_LOW:  st <= S_RS_HIGH;
          S_RS_HIGH: st <= S_START;
          S_P_LOW:   st <= S_P_HIGH;
          S_P_HIGH:  st <= S_P_END;
          S_P_END: begin
            st   <= S_IDLE;
            done <= 1'b1;
          end
          default:   st <= S_IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;

  p_sda_only_start_stop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && !scl_oe && !$past(scl_oe) && (sda_oe != $past(sda_oe)))
      |-> ((st == S_START && sda_oe) || (st == S_P_END && !sda_oe)));

  p_idle_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!scl_oe && !sda_oe));

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_rd_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && !busy && !$past(busy)) |-> $stable(rd_data));

  p_busy_latch_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && busy && $past(busy))
      |-> ($stable(dev_q) && $stable(rd_q) && $stable(mem_q) && $stable(wd_q)));

  p_nack_stop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err) |-> (st == S_P_LOW));

  p_half_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $past(busy) && (st != $past(st))) |-> ($past(cnt) == '0));

endmodule

// File: tb/i2c_ee_byte_master_tb.sv
module i2c_ee_byte_master_tb;
  localparam int CW = 12;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [CW-1:0] half_cnt = CW'(2);
  logic          start = 1'b0;
  logic          rd_nwr = 1'b0;
  logic [6:0]    dev_addr = '0;
  logic [7:0]    mem_addr = '0;
  logic [7:0]    wr_data = '0;
  logic          busy, done, err, scl_oe, sda_oe;
  logic [7:0]    rd_data;
  logic          pull = 1'b0;
  wire           sda_line = !(sda_oe || pull);

  always #5 clk = ~clk;

  i2c_ee_byte_master #(.CW(CW)) u_dut (
    .clk(clk), .rst_n(rst_n), .half_cnt(half_cnt), .start(start), .rd_nwr(rd_nwr),
    .dev_addr(dev_addr), .mem_addr(mem_addr), .wr_data(wr_data), .busy(busy),
    .done(done), .err(err), .rd_data(rd_data), .scl_oe(scl_oe), .sda_oe(sda_oe),
    .sda_in(sda_line)
  );

  int nchk = 0, nfail = 0;
  logic [2:0] q[$];
  int hh = 1;
  bit exp_done = 0, exp_err = 0, ended = 0;
  logic [7:0] exp_rd = 8'h00;
  string cur_tag = "R10";

  task automatic chk(bit ok, string tag, int act, int expv);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s at %0t: actual %0h expected %0h", tag, $time, act, expv);
    end
  endtask

  task automatic summary();
    if (!ended) begin
      ended = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  endtask

  task automatic hp(bit s, bit d, bit p);
    for (int i = 0; i < hh; i++) q.push_back({s, d, p});
  endtask
  task automatic sta(); hp(0, 1, 0); endtask
  task automatic stp(); hp(1, 1, 0); hp(0, 1, 0); hp(0, 0, 0); endtask
  task automatic txb(logic [7:0] b, bit ack);
    for (int i = 7; i >= 0; i--) begin hp(1, !b[i], 0); hp(0, !b[i], 0); end
    hp(1, 0, ack); hp(0, 0, ack);
  endtask
  task automatic rxb(logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin hp(1, 0, !b[i]); hp(0, 0, !b[i]); end
    hp(1, 0, 0); hp(0, 0, 0);
  endtask

  // nack_at: index of transmitted byte answered with NACK, 9 = none
  task automatic go(bit rw, logic [6:0] dv, logic [7:0] ma, logic [7:0] wd,
                    logic [7:0] rx, int nack_at, int hc, string tag);
    @(posedge clk); #1;
    half_cnt = CW'(hc); rd_nwr = rw; dev_addr = dv; mem_addr = ma; wr_data = wd;
    start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
    cur_tag = tag;
    hh = (hc == 0) ? 1 : hc;
    sta();
    txb({dv, 1'b0}, nack_at != 0);
    if (nack_at == 0) stp();
    else begin
      txb(ma, nack_at != 1);
      if (nack_at == 1) stp();
      else if (!rw) begin txb(wd, nack_at != 2); stp(); end
      else begin
        hp(1, 0, 0); hp(0, 0, 0); sta();
        txb({dv, 1'b1}, nack_at != 2);
        if (nack_at != 2) rxb(rx);
        stp();
      end
    end
    exp_err = (nack_at <= 2);
    if (rw && nack_at > 2) exp_rd = rx;
  endtask

  task automatic idle_gap(); wait (q.size() == 0); repeat (3) @(posedge clk); endtask

  // cycle-by-cycle comparison with the reference waveform (R1 R2 R3 R5 R6)
  always @(negedge clk) if (rst_n && !ended) begin
    if (q.size() > 0) begin
      logic [2:0] e;
      e = q.pop_front();
      pull = e[0];
      chk(scl_oe == e[2] && sda_oe == e[1] && busy && !done,
          {cur_tag, " R1/R6 waveform"}, {busy, done, scl_oe, sda_oe}, {2'b10, e[2:1]});
      if (q.size() == 0) exp_done = 1;
    end else begin
      pull = 1'b0;
      chk(!scl_oe && !sda_oe && !busy, "R5 idle release", {busy, scl_oe, sda_oe}, 0);
      if (exp_done) begin
        exp_done = 0;
        chk(done, {cur_tag, " R9 done pulse"}, done, 1);
        chk(err == exp_err, {cur_tag, " R7 err"}, err, exp_err);
        chk(rd_data == exp_rd, {cur_tag, " R9 rd_data"}, rd_data, exp_rd);
      end else
        chk(!done, "R9 single done", done, 0);
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog expired: actual hung expected finished");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!scl_oe && !sda_oe && !busy && !done && !err && rd_data == 0, "R10 reset",
        {scl_oe, sda_oe, busy, done, err, rd_data}, 0);
    #2 rst_n = 1'b1;
    repeat (2) @(posedge clk);
    go(0, 7'h50, 8'h3A, 8'hC5, 8'h00, 9, 3, "R2 write");
    idle_gap();
    go(1, 7'h50, 8'h81, 8'h00, 8'hA5, 9, 2, "R3 read");
    wait (q.size() == 0);
    go(1, 7'h2B, 8'hFF, 8'h00, 8'h3C, 9, 1, "R11 back-to-back");
    idle_gap();
    go(0, 7'h11, 8'h22, 8'h33, 8'h00, 0, 2, "R7 nack dev");
    idle_gap();
    go(1, 7'h51, 8'h10, 8'h00, 8'h99, 1, 2, "R7 nack mem");
    idle_gap();
    go(0, 7'h6E, 8'h00, 8'h7F, 8'h00, 2, 1, "R7 nack data");
    idle_gap();
    go(0, 7'h50, 8'h05, 8'h01, 8'h00, 9, 2, "R8 busy start");
    repeat (40) @(posedge clk);
    #1 start = 1'b1; rd_nwr = 1'b1; dev_addr = 7'h7F; mem_addr = 8'hEE; wr_data = 8'h00;
    @(posedge clk); #1 start = 1'b0;
    idle_gap();
    go(1, 7'h50, 8'h40, 8'h00, 8'h5A, 9, 0, "R4 zero half");
    idle_gap();
    go(1, 7'h50, 8'h41, 8'h00, 8'h81, 9, 5, "R4 long half");
    idle_gap();
    summary();
  end
endmodule